// File: doc/BRIEF.md
# Chip Sleep Entry Sequencer

This block carries a processor from normal running into a chip-level sleep state without software help once the processor has issued its standby wait-for-interrupt, and it brings the chip back when an enabled wake source fires. It is split between a clock-and-reset controller and an always-on low-power controller. The clock-and-reset controller gates the processor and traffic-controller clock domains, asks the DPLL to idle and then raises a chip-idle handshake. The always-on controller answers that handshake by stopping the main input clock, raising a chip-wakeup indication and settling into sleep.

Software prepares the entry beforehand. Per-domain idle-enable bits pick the domains that gate. Two further enables allow the DPLL and the traffic controller to idle. A power-control word enables low-power operation, chooses big or deep sleep and decides whether the oscillator stops. A wake-enable mask picks which wake sources may end sleep. On exit the steps run in reverse order. When the oscillator was stopped, a programmable settle count is inserted before the handshake is released.

Top module: `sleep_entry_seq`

## Requirements
- R1: After reset all domain clock enables are 1, the input clock enable and oscillator enable are 1, and the DPLL idle request, chip-idle, chip-wakeup and sleep indication are 0.
- R2: A standby request with no wake pending gates, in the next cycle, exactly the domains whose `dom_idle_en` bit is 1. The other domains keep running.
- R3: The DPLL idle request is raised only when every `dom_idle_en` bit, `dpll_idle_en` and `tc_idle_en` are all 1. Otherwise the sequence holds with the domains gated until a wake, and then restores every domain.
- R4: Chip-idle rises only after the DPLL has acknowledged idle, and it is never high while a domain clock is enabled or the DPLL request is low.
- R5: When `pwr_ctrl` bit 0 is 1, chip-idle makes the input clock enable drop and chip-wakeup rise in the next cycle, and the sleep indication rises one cycle later. When bit 0 is 0 the input clock stays on and the handshake is held until a wake.
- R6: The oscillator enable drops during sleep only when `pwr_ctrl` bit 4 (deep sleep) and bit 9 (oscillator stop) are both 1. In big sleep (bit 4 = 0) it stays on.
- R7: A wake is any `wake_src` bit whose `wake_en` bit is 1. A source with its enable at 0 has no effect on a sleeping chip.
- R8: On wake the input clock returns first. If the oscillator was stopped, chip-idle and the DPLL request drop together `settle_cnt`+1 cycles after the clock returns, with a count of 0 acting as 1. Otherwise they drop 1 cycle after it. The domains are restored only after the DPLL acknowledge has fallen.
- R9: A standby request and a wake in the same cycle leave every output unchanged: the wake wins.
- R10: A wake during entry is remembered. During domain gating it restores the domains at once. After the DPLL request it lets entry finish and then leaves sleep immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby_wfi | input | 1 | Processor standby wait-for-interrupt request |
| dom_idle_en | input | NDOM | Per-domain permission to gate |
| dpll_idle_en | input | 1 | Permission for the DPLL to idle |
| tc_idle_en | input | 1 | Permission for the traffic controller to idle |
| pwr_ctrl | input | PCR_W | Power-control word: bit 0 low-power enable, bit 4 deep sleep, bit 9 oscillator stop |
| wake_src | input | NWAKE | Wake source events |
| wake_en | input | NWAKE | Wake source enable mask |
| settle_cnt | input | CNT_W | Oscillator/DPLL settle cycles on exit |
| dpll_idle_ack | input | 1 | DPLL idle acknowledge |
| dom_clk_en | output | NDOM | Domain clock enables |
| dpll_idle_req | output | 1 | DPLL idle request |
| chip_idle | output | 1 | Chip-idle handshake to the always-on controller |
| chip_wakeup | output | 1 | Chip-wakeup indication while the input clock is off |
| in_clk_en | output | 1 | Main input clock enable |
| osc_en | output | 1 | Oscillator enable |
| proc_asleep | output | 1 | Processor domain inactive (sleep state) |

## Verification
Two of the block's functions can collide in one cycle: accepting a standby request and recognising a wake. The bench raises `standby_wfi` and an enabled wake source on the same clock edge, and it requires that no output event follows. It then offsets the wake by one cycle and by two cycles so that it lands during domain gating and during the DPLL wait. For each offset it judges the resulting event trace against the remembered-wake rules.

// File: rtl/sleep_seq_pkg.sv
// Shared state encodings for the sleep entry sequencer.
// Assumes: both controllers run on the always-on clock.
package sleep_seq_pkg;

    // States of the clock-and-reset controller
    typedef enum logic [2:0] {
        CR_RUN   = 3'd0,   // all domains running
        CR_GATE  = 3'd1,   // selected domains gated, deciding next step
        CR_HOLD  = 3'd2,   // partial idle, waiting for wake
        CR_PLL   = 3'd3,   // DPLL idle requested, waiting acknowledge
        CR_IDLE  = 3'd4,   // chip-idle raised
        CR_PLLUP = 3'd5    // DPLL request dropped, waiting acknowledge low
    } cr_state_t;

    // States of the always-on low-power controller
    typedef enum logic [2:0] {
        AO_ON     = 3'd0,  // input clock running
        AO_CUT    = 3'd1,  // input clock just gated
        AO_SLEEP  = 3'd2,  // sleep state
        AO_SETTLE = 3'd3,  // oscillator / DPLL settle count
        AO_REL    = 3'd4   // release handshake to clock controller
    } ao_state_t;

endpackage

// File: rtl/slp_wake_latch.sv
// Wake detection: qualifies wake sources by their enable mask and
// remembers a wake seen while a sleep sequence is in progress.
// Assumes: seq_busy is high from domain gating until domains restore.
module slp_wake_latch #(
    parameter int NWAKE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NWAKE-1:0] wake_src,
    input  logic [NWAKE-1:0] wake_en,
    input  logic             seq_busy,
    output logic             wake_any
);
    logic wake_now;
    logic pend_q;

    // Purpose: combine sources with their enable mask
    assign wake_now = |(wake_src & wake_en);

    // Purpose: hold a wake until the sequence returns to running
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (seq_busy)
            pend_q <= pend_q | wake_now;
        else
            pend_q <= 1'b0;
    end

    assign wake_any = wake_now | pend_q;
endmodule

// File: rtl/slp_clk_ctrl.sv
// Clock-and-reset controller: gates domains on standby, idles the DPLL,
// raises chip-idle, and reverses on release from the always-on side.
// Assumes: the DPLL acknowledge follows the request with any latency.
module slp_clk_ctrl
    import sleep_seq_pkg::*;
#(
    parameter int NDOM = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            standby_wfi,
    input  logic [NDOM-1:0] dom_idle_en,
    input  logic            dpll_idle_en,
    input  logic            tc_idle_en,
    input  logic            dpll_idle_ack,
    input  logic            wake_any,
    input  logic            aon_release,
    output logic [NDOM-1:0] dom_clk_en,
    output logic            dpll_idle_req,
    output logic            chip_idle,
    output logic            seq_busy
);
    cr_state_t       state_q, state_d;
    logic            full_idle;
    logic [NDOM-1:0] dom_d;
    logic            req_d, idle_d;

    // Purpose: full chip idle is allowed only with every permission set
    assign full_idle = (&dom_idle_en) & dpll_idle_en & tc_idle_en;

    // Purpose: next-state selection for the entry and exit sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CR_RUN:   if (standby_wfi && !wake_any) state_d = CR_GATE;
            CR_GATE:  if (wake_any)       state_d = CR_RUN;
                      else if (full_idle) state_d = CR_PLL;
                      else                state_d = CR_HOLD;
            CR_HOLD:  if (wake_any)       state_d = CR_RUN;
            CR_PLL:   if (dpll_idle_ack)  state_d = CR_IDLE;
            CR_IDLE:  if (aon_release)    state_d = CR_PLLUP;
            CR_PLLUP: if (!dpll_idle_ack) state_d = CR_RUN;
            default:  state_d = CR_RUN;
        endcase
    end

    // Purpose: output values that belong to the next state
    always_comb begin
        if (state_d == CR_RUN)
            dom_d = '1;
        else if (state_d == CR_GATE || state_d == CR_HOLD)
            dom_d = ~dom_idle_en;
        else
            dom_d = '0;
        req_d  = (state_d == CR_PLL) || (state_d == CR_IDLE);
        idle_d = (state_d == CR_IDLE);
    end

    // Purpose: state and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= CR_RUN;
            dom_clk_en    <= '1;
            dpll_idle_req <= 1'b0;
            chip_idle     <= 1'b0;
        end else begin
            state_q       <= state_d;
            dom_clk_en    <= dom_d;
            dpll_idle_req <= req_d;
            chip_idle     <= idle_d;
        end
    end

    assign seq_busy = (state_q != CR_RUN);
endmodule

// File: rtl/slp_settle_timer.sv
// Down-counter for the oscillator / DPLL settle interval on wake.
// Assumes: load pulses one cycle before the counted interval starts;
// done is high in the last counted cycle (a value of 0 counts as 1).
module slp_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Purpose: load the settle count and run it down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= value;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/slp_aon_ctrl.sv
// Always-on low-power controller: answers chip-idle by gating the input
// clock, enters sleep, and on wake restores clock and oscillator, waits
// the settle count if needed, then releases the handshake.
// Assumes: chip_idle stays high until aon_release has been seen.
module slp_aon_ctrl
    import sleep_seq_pkg::*;
#(
    parameter int PCR_W    = 16,
    parameter int LP_BIT   = 0,
    parameter int DEEP_BIT = 4,
    parameter int OSC_BIT  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_idle,
    input  logic             wake_any,
    input  logic [PCR_W-1:0] pwr_ctrl,
    input  logic             tmr_done,
    output logic             in_clk_en,
    output logic             chip_wakeup,
    output logic             osc_en,
    output logic             proc_asleep,
    output logic             aon_release,
    output logic             tmr_load
);
    ao_state_t state_q, state_d;
    logic      osc_off_q;

    // Purpose: next-state selection for the low-power controller
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AO_ON:     if (chip_idle) begin
                           if (pwr_ctrl[LP_BIT]) state_d = AO_CUT;
                           else if (wake_any)    state_d = AO_REL;
                       end
            AO_CUT:    state_d = AO_SLEEP;
            AO_SLEEP:  if (wake_any) state_d = osc_off_q ? AO_SETTLE : AO_REL;
            AO_SETTLE: if (tmr_done) state_d = AO_REL;
            AO_REL:    state_d = AO_ON;
            default:   state_d = AO_ON;
        endcase
    end

    // Purpose: state register and oscillator-stop decision at sleep entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= AO_ON;
            osc_off_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == AO_CUT)
                osc_off_q <= pwr_ctrl[DEEP_BIT] & pwr_ctrl[OSC_BIT];
        end
    end

    // Purpose: decode outputs from the registered state
    assign in_clk_en   = !(state_q == AO_CUT || state_q == AO_SLEEP);
    assign chip_wakeup = (state_q == AO_CUT) || (state_q == AO_SLEEP);
    assign proc_asleep = (state_q == AO_SLEEP);
    assign osc_en      = !((state_q == AO_SLEEP) && osc_off_q);
    assign aon_release = (state_q == AO_REL);
    assign tmr_load    = (state_q == AO_SLEEP) && wake_any && osc_off_q;
endmodule

// File: rtl/sleep_entry_seq.sv
// Top of the chip sleep entry sequencer: ties the clock-and-reset
// controller, the always-on controller, wake qualification and the
// settle timer together.
// Assumes: configuration inputs are static while a sequence runs.
module sleep_entry_seq #(
    parameter int NDOM     = 4,
    parameter int NWAKE    = 4,
    parameter int CNT_W    = 8,
    parameter int PCR_W    = 16,
    parameter int LP_BIT   = 0,
    parameter int DEEP_BIT = 4,
    parameter int OSC_BIT  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby_wfi,
    input  logic [NDOM-1:0]  dom_idle_en,
    input  logic             dpll_idle_en,
    input  logic             tc_idle_en,
    input  logic [PCR_W-1:0] pwr_ctrl,
    input  logic [NWAKE-1:0] wake_src,
    input  logic [NWAKE-1:0] wake_en,
    input  logic [CNT_W-1:0] settle_cnt,
    input  logic             dpll_idle_ack,
    output logic [NDOM-1:0]  dom_clk_en,
    output logic             dpll_idle_req,
    output logic             chip_idle,
    output logic             chip_wakeup,
    output logic             in_clk_en,
    output logic             osc_en,
    output logic             proc_asleep
);
    logic wake_any, seq_busy, aon_release, tmr_load, tmr_done;

    slp_wake_latch #(.NWAKE(NWAKE)) u_wake (
        .clk(clk), .rst_n(rst_n), .wake_src(wake_src), .wake_en(wake_en),
        .seq_busy(seq_busy), .wake_any(wake_any)
    );

    slp_clk_ctrl #(.NDOM(NDOM)) u_crc (
        .clk(clk), .rst_n(rst_n), .standby_wfi(standby_wfi),
        .dom_idle_en(dom_idle_en), .dpll_idle_en(dpll_idle_en),
        .tc_idle_en(tc_idle_en), .dpll_idle_ack(dpll_idle_ack),
        .wake_any(wake_any), .aon_release(aon_release),
        .dom_clk_en(dom_clk_en), .dpll_idle_req(dpll_idle_req),
        .chip_idle(chip_idle), .seq_busy(seq_busy)
    );

    slp_settle_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .value(settle_cnt),
        .done(tmr_done)
    );

    slp_aon_ctrl #(
        .PCR_W(PCR_W), .LP_BIT(LP_BIT), .DEEP_BIT(DEEP_BIT), .OSC_BIT(OSC_BIT)
    ) u_aon (
        .clk(clk), .rst_n(rst_n), .chip_idle(chip_idle), .wake_any(wake_any),
        .pwr_ctrl(pwr_ctrl), .tmr_done(tmr_done), .in_clk_en(in_clk_en),
        .chip_wakeup(chip_wakeup), .osc_en(osc_en), .proc_asleep(proc_asleep),
        .aon_release(aon_release), .tmr_load(tmr_load)
    );
endmodule

// File: rtl/sleep_entry_seq_chk.sv
// Protocol checker for the sleep entry sequencer, bound to the top.
// Assumes: observes only ports of the top module.
module sleep_entry_seq_chk #(
    parameter int NDOM = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dpll_idle_ack,
    input logic [NDOM-1:0] dom_clk_en,
    input logic            dpll_idle_req,
    input logic            chip_idle,
    input logic            chip_wakeup,
    input logic            in_clk_en,
    input logic            osc_en,
    input logic            proc_asleep
);
    // R4: chip-idle only with every domain off and the DPLL request held
    assert_idle_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chip_idle |-> (dom_clk_en == '0) && dpll_idle_req);

    // R4: chip-idle rises only after the DPLL acknowledge was seen
    assert_idle_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_idle) |-> $past(dpll_idle_ack));

    // R5: input clock is off only inside the chip-idle handshake
    assert_clk_off_in_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_clk_en |-> chip_idle);

    // R5: chip-wakeup rises only after chip-idle was already high
    assert_wakeup_after_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_wakeup) |-> $past(chip_idle));

    // R6: oscillator stops only in the sleep state
    assert_osc_off_asleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> proc_asleep && !in_clk_en);

    // R8: domains come back only after the handshake has been released
    assert_restore_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dom_clk_en) == '0 && dom_clk_en != '0) |-> !chip_idle && !dpll_idle_req);
endmodule

bind sleep_entry_seq sleep_entry_seq_chk #(.NDOM(NDOM)) u_chk (
    .clk(clk), .rst_n(rst_n), .dpll_idle_ack(dpll_idle_ack),
    .dom_clk_en(dom_clk_en), .dpll_idle_req(dpll_idle_req),
    .chip_idle(chip_idle), .chip_wakeup(chip_wakeup), .in_clk_en(in_clk_en),
    .osc_en(osc_en), .proc_asleep(proc_asleep)
);

// File: tb/sleep_entry_seq_test.sv
// Scoreboard bench: scenario tasks queue the expected output events,
// a monitor compares every change of the outputs against the queue.
module sleep_entry_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby_wfi = 1'b0;
    logic [3:0]  dom_idle_en = 4'hF;
    logic        dpll_idle_en = 1'b1, tc_idle_en = 1'b1;
    logic [15:0] pwr_ctrl = '0;
    logic [3:0]  wake_src = '0;
    logic [3:0]  wake_en = 4'b0011;
    logic [7:0]  settle_cnt = 8'd5;
    logic        dpll_idle_ack;
    logic [3:0]  dom_clk_en;
    logic        dpll_idle_req, chip_idle, chip_wakeup, in_clk_en, osc_en, proc_asleep;

    int checks = 0, errors = 0;

    typedef struct {
        logic [9:0] snap;
        int         gap;
        string      tag;
    } ev_t;
    ev_t exp_q[$];

    always #4 clk = ~clk;   // 125 MHz

    sleep_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .standby_wfi(standby_wfi),
        .dom_idle_en(dom_idle_en), .dpll_idle_en(dpll_idle_en),
        .tc_idle_en(tc_idle_en), .pwr_ctrl(pwr_ctrl), .wake_src(wake_src),
        .wake_en(wake_en), .settle_cnt(settle_cnt), .dpll_idle_ack(dpll_idle_ack),
        .dom_clk_en(dom_clk_en), .dpll_idle_req(dpll_idle_req),
        .chip_idle(chip_idle), .chip_wakeup(chip_wakeup), .in_clk_en(in_clk_en),
        .osc_en(osc_en), .proc_asleep(proc_asleep)
    );

    // DPLL model: acknowledge follows the request by one clock
    always @(posedge clk) begin
        if (!rst_n) dpll_idle_ack <= 1'b0;
        else        dpll_idle_ack <= dpll_idle_req;
    end

    function automatic logic [9:0] mk(input logic [3:0] d, input logic rq,
        input logic id, input logic ck, input logic wk, input logic os, input logic sl);
        return {d, rq, id, ck, wk, os, sl};
    endfunction

    function automatic logic [9:0] now_snap();
        return {dom_clk_en, dpll_idle_req, chip_idle, in_clk_en, chip_wakeup, osc_en, proc_asleep};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input logic [9:0] s, input int gap, input string tag);
        ev_t e;
        e.snap = s; e.gap = gap; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: pop and compare on every output change
    bit         mon_on = 1'b0;
    logic [9:0] prev_snap;
    int         cyc = 0, last_cyc = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            logic [9:0] cur;
            cyc++;
            cur = now_snap();
            if (cur !== prev_snap) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected output change", cur, prev_snap);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    chk(cur === e.snap, e.tag, "output event", cur, e.snap);
                    if (e.gap > 0)
                        chk(cyc - last_cyc == e.gap, e.tag, "event spacing",
                            cyc - last_cyc, e.gap);
                end
                prev_snap = cur;
                last_cyc  = cyc;
            end
        end
    end

    task automatic pulse_standby(input bit with_wake);
        @(negedge clk);
        standby_wfi = 1'b1;
        if (with_wake) wake_src[0] = 1'b1;
        @(negedge clk);
        standby_wfi = 1'b0;
        wake_src[0] = 1'b0;
    endtask

    task automatic pulse_wake(input int idx);
        wake_src[idx] = 1'b1;
        @(negedge clk);
        wake_src[idx] = 1'b0;
    endtask

    task automatic drain(input string req);
        repeat (30) @(negedge clk);
        chk(exp_q.size() == 0, req, "events left in queue", exp_q.size(), 0);
    endtask

    // Full sleep round trip under a given power-control word
    task automatic sleep_trip(input logic [15:0] pcr, input logic [7:0] n, input string tag);
        bit lp, off;
        int g;
        lp  = pcr[0];
        off = pcr[4] & pcr[9];
        pwr_ctrl = pcr; settle_cnt = n;
        g = off ? ((n < 1) ? 2 : int'(n) + 1) : 1;
        expect_ev(mk(4'h0, 0, 0, 1, 0, 1, 0), 0, "R2");
        expect_ev(mk(4'h0, 1, 0, 1, 0, 1, 0), 0, "R3");
        expect_ev(mk(4'h0, 1, 1, 1, 0, 1, 0), 0, "R4");
        if (lp) begin
            expect_ev(mk(4'h0, 1, 1, 0, 1, 1, 0), 0, "R5");
            expect_ev(mk(4'h0, 1, 1, 0, 1, !off, 1), 1, {"R6 ", tag});
            expect_ev(mk(4'h0, 1, 1, 1, 0, 1, 0), 0, "R8");
            expect_ev(mk(4'h0, 0, 0, 1, 0, 1, 0), g, {"R8 ", tag});
        end else begin
            expect_ev(mk(4'h0, 0, 0, 1, 0, 1, 0), 0, "R5");
        end
        expect_ev(mk(4'hF, 0, 0, 1, 0, 1, 0), 2, "R8");
        pulse_standby(1'b0);
        for (int i = 0; i < 40 && !(lp ? proc_asleep : chip_idle); i++) @(negedge clk);
        repeat (3) @(negedge clk);
        if (lp) begin
            pulse_wake(3);   // source 3 is not enabled
            repeat (4) @(negedge clk);
            chk(proc_asleep && !in_clk_en, "R7", "masked wake left sleep",
                {proc_asleep, in_clk_en}, 2'b10);
        end
        pulse_wake(0);
        drain(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(now_snap() === mk(4'hF, 0, 0, 1, 0, 1, 0), "R1", "reset outputs",
            now_snap(), mk(4'hF, 0, 0, 1, 0, 1, 0));
        prev_snap = now_snap();
        mon_on = 1'b1;

        sleep_trip(16'h0211, 8'd5, "deep osc stop settle 5");
        sleep_trip(16'h0211, 8'd0, "deep osc stop settle 0");
        sleep_trip(16'h0201, 8'd5, "big sleep");
        sleep_trip(16'h0011, 8'd5, "deep osc running");
        sleep_trip(16'h0210, 8'd5, "low power off");

        // R2 partial gating, R3 hold then full restore
        dom_idle_en = 4'b0101;
        expect_ev(mk(4'b1010, 0, 0, 1, 0, 1, 0), 0, "R2");
        expect_ev(mk(4'hF, 0, 0, 1, 0, 1, 0), 0, "R3");
        pulse_standby(1'b0);
        repeat (6) @(negedge clk);
        pulse_wake(1);
        drain("R3 partial");
        dom_idle_en = 4'hF;

        // R3 DPLL not allowed: domains gated, no DPLL request
        dpll_idle_en = 1'b0;
        expect_ev(mk(4'h0, 0, 0, 1, 0, 1, 0), 0, "R2");
        expect_ev(mk(4'hF, 0, 0, 1, 0, 1, 0), 0, "R3");
        pulse_standby(1'b0);
        repeat (6) @(negedge clk);
        chk(!dpll_idle_req, "R3", "DPLL request without permission", dpll_idle_req, 0);
        pulse_wake(0);
        drain("R3 no dpll");
        dpll_idle_en = 1'b1;

        // R9 standby and wake in the same cycle
        pulse_standby(1'b1);
        repeat (10) @(negedge clk);
        chk(dom_clk_en === 4'hF, "R9", "domains after simultaneous wake", dom_clk_en, 4'hF);
        drain("R9");

        // R10 wake during domain gating
        pwr_ctrl = 16'h0201;
        expect_ev(mk(4'h0, 0, 0, 1, 0, 1, 0), 0, "R10");
        expect_ev(mk(4'hF, 0, 0, 1, 0, 1, 0), 1, "R10");
        @(negedge clk);
        standby_wfi = 1'b1;
        @(negedge clk);
        standby_wfi = 1'b0;
        pulse_wake(0);
        drain("R10 gate");

        // R10 wake during DPLL wait: entry completes, then exits at once
        expect_ev(mk(4'h0, 0, 0, 1, 0, 1, 0), 0, "R10");
        expect_ev(mk(4'h0, 1, 0, 1, 0, 1, 0), 0, "R10");
        expect_ev(mk(4'h0, 1, 1, 1, 0, 1, 0), 0, "R10");
        expect_ev(mk(4'h0, 1, 1, 0, 1, 1, 0), 0, "R10");
        expect_ev(mk(4'h0, 1, 1, 0, 1, 1, 1), 1, "R10");
        expect_ev(mk(4'h0, 1, 1, 1, 0, 1, 0), 1, "R10");
        expect_ev(mk(4'h0, 0, 0, 1, 0, 1, 0), 1, "R10");
        expect_ev(mk(4'hF, 0, 0, 1, 0, 1, 0), 2, "R10");
        @(negedge clk);
        standby_wfi = 1'b1;
        @(negedge clk);
        standby_wfi = 1'b0;
        @(negedge clk);
        pulse_wake(1);
        drain("R10 pll");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule